// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block chooses which of three incoming reference clocks feeds a downstream timing path. The three references have fixed roles: primary, secondary and standby. Each one is watched by an activity monitor that runs on the local system clock (a 12.80 MHz oscillator in the intended system). The block changes its choice on its own when a reference stops toggling.

The primary is preferred. When the primary fails, the block moves to the secondary. It moves to the standby only when both the primary and the secondary are down. An external force input can choose between the primary and the secondary directly, as long as the forced reference is healthy. A control bit chooses between two modes. In revertive mode the block returns to the primary once it recovers. In non-revertive mode the block stays on a healthy secondary.

The block drives a select code, one failure flag per input, a holdover flag and a one-cycle switch pulse. A small word-addressed register port exposes the control settings and a status word.

Top module: `refsel_top`

## Requirements
- R1: Each reference passes through a two-flop synchroniser, and its rising edges are detected on the system clock. A monitor sets the input's `fail` bit (bit 0 primary, bit 1 secondary, bit 2 standby) at the end of any window of system clocks that contains no rising edge.
- R2: A failed input becomes good again at the end of the 16th consecutive window that contains a rising edge. A window with no edge restarts that count.
- R3: The window length in system clocks is set by register address 1, bits [WIN_W-1:0]. Its reset value is 64.
- R4: In revertive mode (address 0 bit 0 = 0), the select code is 0 (primary) whenever the primary is not failed and no force applies.
- R5: When the primary is failed and the secondary is not, the select code becomes 1 (secondary). A select code never names an input that was failed in the previous cycle unless holdover is active.
- R6: The select code is 2 (standby) only when both the primary and the secondary were failed in the previous cycle.
- R7: In non-revertive mode (address 0 bit 0 = 1), a selection on a healthy secondary is kept even after the primary recovers.
- R8: When `force_en` is high and the input named by `force_sel` (0 primary, 1 secondary) is not failed, that input is selected. If it is failed, selection follows the automatic rules.
- R9: While all three inputs are failed, `holdover` is 1 and the select code keeps its last value.
- R10: `switch_pulse` is high for exactly the one cycle in which a new select code first appears. A sticky flag (status bit 6) sets one cycle later. Writing 1 to bit 6 at address 2 clears it, and a new pulse wins over a clear in the same cycle.
- R11: A read returns, one cycle after the address is presented: address 0 → {nonrevertive bit}; address 1 → window length; address 2 → {sticky[6], select[5:4], holdover[3], fail[2:0]}; address 3 → 0.
- R12: After reset the select code is 0, all fail flags, holdover, the pulse and the sticky flag are 0, the mode is revertive and the window is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 3 | References: bit 0 primary, bit 1 secondary, bit 2 standby |
| force_en | input | 1 | Enable forced primary/secondary choice |
| force_sel | input | 1 | Forced choice: 0 primary, 1 secondary |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| sel | output | 2 | Select code: 0 primary, 1 secondary, 2 standby |
| fail | output | 3 | Per-input failure flags |
| holdover | output | 1 | All inputs failed |
| switch_pulse | output | 1 | One-cycle pulse on a change of select code |

## Verification
Internal faults in this block surface at the ports at predictable times. A wrong window counter or a wrong edge detector moves the cycle in which a `fail` bit rises or falls. That shows up at the end of the affected window, at most a few hundred cycles after a reference stops or restarts. A wrong recovery count delays or advances the fall of `fail` by one window. A wrong priority or mode decision puts a wrong `sel` value on the port one cycle after the fail flags change, and a missing pulse or sticky bit appears on `switch_pulse` or in the status word within two cycles. The bench runs a behavioural model of the window, recovery and tier rules. It compares every output on every clock, so any of these faults is caught in the first cycle it shows.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SEL_PRI  = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_STBY = 2'd2
  } sel_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_WINDOW = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam int         STICKY_BIT = 6;
endpackage

// File: rtl/refsel_actmon.sv
module refsel_actmon #(
  parameter int WIN_W     = 16,
  parameter int GOOD_WINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             fail_o
);
  localparam int GW = (GOOD_WINS > 2) ? $clog2(GOOD_WINS) : 1;

  logic [2:0]       sync_q;
  logic [WIN_W-1:0] cnt_q;
  logic [GW-1:0]    good_q;
  logic             seen_q;
  logic             rise;
  logic             win_end;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign win_end = (cnt_q >= (win_len_i - WIN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      cnt_q  <= '0;
      good_q <= '0;
      seen_q <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ref_i};
      if (win_end) begin
        cnt_q  <= '0;
        seen_q <= 1'b0;
        if (seen_q | rise) begin
          if (fail_o) begin
            if (good_q == GW'(GOOD_WINS - 1)) begin
              fail_o <= 1'b0;
              good_q <= '0;
            end else begin
              good_q <= good_q + GW'(1);
            end
          end
        end else begin
          fail_o <= 1'b1;
          good_q <= '0;
        end
      end else begin
        cnt_q  <= cnt_q + WIN_W'(1);
        seen_q <= seen_q | rise;
      end
    end
  end

  // R1: a failure is only declared at the close of a window
  p_fail_at_window_end_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> $past(win_end));
  // R2: recovery only after the full run of good windows
  p_recover_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_o) |-> ($past(good_q) == GW'(GOOD_WINS - 1)));
endmodule

// File: rtl/refsel_arb.sv
module refsel_arb
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] fail_i,
  input  logic       force_en_i,
  input  logic       force_sel_i,
  input  logic       nonrev_i,
  output sel_e       sel_o,
  output logic       hold_o,
  output logic       sw_o
);
  sel_e       sel_n;
  logic [2:0] fail_p;
  sel_e       sel_p;

  always_comb begin
    if (nonrev_i && sel_o == SEL_SEC && !fail_i[1]) sel_n = SEL_SEC;
    else if (!fail_i[0])                            sel_n = SEL_PRI;
    else if (!fail_i[1])                            sel_n = SEL_SEC;
    else                                            sel_n = SEL_STBY;
    if (force_en_i && !fail_i[force_sel_i])
      sel_n = force_sel_i ? SEL_SEC : SEL_PRI;
    if (&fail_i) sel_n = sel_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= SEL_PRI;
      hold_o <= 1'b0;
      sw_o   <= 1'b0;
      fail_p <= '0;
      sel_p  <= SEL_PRI;
    end else begin
      sel_o  <= sel_n;
      hold_o <= &fail_i;
      sw_o   <= (sel_n != sel_o);
      fail_p <= fail_i;
      sel_p  <= sel_o;
    end
  end

  p_standby_needs_both_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_o == SEL_STBY) |-> (fail_p[0] && fail_p[1]));
  p_sel_healthy_r5: assert property (@(posedge clk) disable iff (rst)
    !hold_o |-> !fail_p[sel_o]);
  p_hold_freezes_r9: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> (sel_o == sel_p));
  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (rst)
    sw_o == (sel_o != sel_p));
endmodule

// File: rtl/refsel_regs.sv
module refsel_regs
  import refsel_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 16,
  parameter int DEF_WIN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [2:0]        fail_i,
  input  logic              hold_i,
  input  logic [1:0]        sel_i,
  input  logic              sw_i,
  output logic              nonrev_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              sticky_q;
  logic [DATA_W-1:0] rd;

  always_comb begin
    rd = '0;
    case (addr_i)
      A_CTRL:   rd[0] = nonrev_o;
      A_WINDOW: rd[WIN_W-1:0] = win_o;
      A_STATUS: rd[STICKY_BIT:0] = {sticky_q, sel_i, hold_i, fail_i};
      default:  rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nonrev_o <= 1'b0;
      win_o    <= WIN_W'(DEF_WIN);
      sticky_q <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rdata_o <= rd;
      if (wr_i && addr_i == A_CTRL)   nonrev_o <= wdata_i[0];
      if (wr_i && addr_i == A_WINDOW) win_o    <= wdata_i[WIN_W-1:0];
      if (sw_i)
        sticky_q <= 1'b1;
      else if (wr_i && addr_i == A_STATUS && wdata_i[STICKY_BIT])
        sticky_q <= 1'b0;
    end
  end

  p_sticky_sets_r10: assert property (@(posedge clk) disable iff (rst)
    sw_i |=> sticky_q);
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WIN_W     = 16,
  parameter int DEF_WIN   = 64,
  parameter int GOOD_WINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ref_in,
  input  logic              force_en,
  input  logic              force_sel,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        sel,
  output logic [2:0]        fail,
  output logic              holdover,
  output logic              switch_pulse
);
  localparam int N_REF = 3;

  logic             nonrev;
  logic [WIN_W-1:0] win_len;
  sel_e             sel_w;

  for (genvar g = 0; g < N_REF; g++) begin : g_mon
    refsel_actmon #(.WIN_W(WIN_W), .GOOD_WINS(GOOD_WINS)) u_mon (
      .clk(clk), .rst(rst), .ref_i(ref_in[g]), .win_len_i(win_len),
      .fail_o(fail[g])
    );
  end

  refsel_arb u_arb (
    .clk(clk), .rst(rst), .fail_i(fail), .force_en_i(force_en),
    .force_sel_i(force_sel), .nonrev_i(nonrev), .sel_o(sel_w),
    .hold_o(holdover), .sw_o(switch_pulse)
  );

  assign sel = sel_w;

  refsel_regs #(.DATA_W(DATA_W), .WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .fail_i(fail), .hold_i(holdover), .sel_i(sel),
    .sw_i(switch_pulse), .nonrev_o(nonrev), .win_o(win_len),
    .rdata_o(reg_rdata)
  );
endmodule

// File: tb/refsel_top_bench.sv
module refsel_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ref_in = 3'b000;
  logic        force_en = 1'b0, force_sel = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  sel;
  logic [2:0]  fail;
  logic        holdover, switch_pulse;

  refsel_top u_refsel_top (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // stimulus clocks
  bit run [3] = '{0, 0, 0};
  int hc  [3] = '{0, 0, 0};
  int half[3] = '{5, 6, 7};
  always @(negedge clk)
    for (int i = 0; i < 3; i++)
      if (run[i]) begin
        hc[i]++;
        if (hc[i] >= half[i]) begin hc[i] = 0; ref_in[i] = ~ref_in[i]; end
      end

  // behavioural reference model
  int m_cnt[3], m_good[3], m_s0[3], m_s1[3], m_s2[3];
  bit m_seen[3], m_fail[3];
  int m_sel, m_win;
  bit m_hold, m_sw, m_nonrev, m_sticky;
  int m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_good[i] = 0; m_s0[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
        m_seen[i] = 0; m_fail[i] = 0;
      end
      m_sel = 0; m_win = 64; m_hold = 0; m_sw = 0; m_nonrev = 0; m_sticky = 0; m_rd = 0;
    end else begin
      int nsel, fv;
      bit nsticky;
      fv = {m_fail[2], m_fail[1], m_fail[0]};
      case (reg_addr)
        0: m_rd = m_nonrev;
        1: m_rd = m_win;
        2: m_rd = (m_sticky << 6) | (m_sel << 4) | (m_hold << 3) | fv;
        default: m_rd = 0;
      endcase
      if (m_nonrev && m_sel == 1 && !m_fail[1]) nsel = 1;
      else if (!m_fail[0]) nsel = 0;
      else if (!m_fail[1]) nsel = 1;
      else nsel = 2;
      if (force_en && !m_fail[force_sel]) nsel = force_sel;
      if (fv == 7) nsel = m_sel;
      nsticky = m_sw ? 1'b1 : ((reg_wr && reg_addr == 2 && reg_wdata[6]) ? 1'b0 : m_sticky);
      for (int i = 0; i < 3; i++) begin
        bit e;
        e = m_s1[i] && !m_s2[i];
        if (m_cnt[i] >= m_win - 1) begin
          if (m_seen[i] || e) begin
            if (m_fail[i]) begin
              if (m_good[i] == 15) begin m_fail[i] = 0; m_good[i] = 0; end
              else m_good[i]++;
            end
          end else begin m_fail[i] = 1; m_good[i] = 0; end
          m_cnt[i] = 0; m_seen[i] = 0;
        end else begin
          m_cnt[i]++; m_seen[i] = m_seen[i] || e;
        end
        m_s2[i] = m_s1[i]; m_s1[i] = m_s0[i]; m_s0[i] = ref_in[i];
      end
      m_hold = (fv == 7);
      m_sw = (nsel != m_sel);
      m_sel = nsel;
      m_sticky = nsticky;
      if (reg_wr && reg_addr == 0) m_nonrev = reg_wdata[0];
      if (reg_wr && reg_addr == 1) m_win = reg_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R1,R2,R3 fail flags", fail, {m_fail[2], m_fail[1], m_fail[0]});
    chk("R4,R5,R6,R7,R8 select", sel, m_sel);
    chk("R9 holdover", holdover, m_hold);
    chk("R10 switch pulse", switch_pulse, m_sw);
    chk("R11 read data", reg_rdata, m_rd);
  end

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  localparam int RECOVER = 17 * 64 + 40;

  initial begin
    reg_addr = 2'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset select", sel, 0);
    chk("R12 reset fail", fail, 0);
    chk("R12 reset holdover", holdover, 0);
    reg_addr = 2'd1; @(negedge clk);
    chk("R12 R3 reset window", reg_rdata, 64);
    reg_addr = 2'd2;
    run = '{1, 1, 1};
    wait_n(300);
    chk("R4 primary chosen", sel, 0);
    run[0] = 0; wait_n(200);
    chk("R5 failover to secondary", sel, 1);
    chk("R1 primary flagged", fail, 3'b001);
    run[0] = 1; wait_n(RECOVER);
    chk("R2 R4 revert to primary", sel, 0);
    wr(2'd2, 16'h0040); wait_n(3);
    chk("R10 sticky cleared", reg_rdata[6], 0);
    wr(2'd0, 16'h0001);
    run[0] = 0; wait_n(200);
    run[0] = 1; wait_n(RECOVER);
    chk("R7 non-revertive keeps secondary", sel, 1);
    run[1] = 0; wait_n(200);
    chk("R7 leaves failed secondary", sel, 0);
    run[0] = 0; wait_n(200);
    chk("R6 standby on double failure", sel, 2);
    run[1] = 1; wait_n(RECOVER);
    chk("R5 secondary over standby", sel, 1);
    force_en = 1; force_sel = 0; wait_n(50);
    chk("R8 forced failed input ignored", sel, 1);
    run[0] = 1; wait_n(RECOVER);
    chk("R8 force primary", sel, 0);
    force_sel = 1; wait_n(20);
    chk("R8 force secondary", sel, 1);
    force_en = 0; wr(2'd0, 16'h0000); wait_n(20);
    chk("R4 back to primary", sel, 0);
    run = '{0, 0, 0}; wait_n(200);
    chk("R9 holdover on all failed", holdover, 1);
    chk("R9 select held", sel, 0);
    wr(2'd1, 16'd20);
    run = '{1, 1, 1}; wait_n(17 * 20 + 40);
    chk("R3 short window recovery", fail, 0);
    run[1] = 0; wait_n(60);
    chk("R3 short window failure", fail, 3'b010);
    reg_addr = 2'd3; wait_n(3);
    chk("R11 unused address", reg_rdata, 0);
    reg_addr = 2'd0; wait_n(3);
    chk("R11 control readback", reg_rdata, 0);
    finish_run();
  end
endmodule